// File: doc/BRIEF.md
# Bit-Serial Two's Complement Negator

This block negates an unsigned-width word that arrives one bit per clock, least significant bit first. It produces the negated word in the same bit order, one bit per clock, without an adder and without a storage register for the word. A single flag tracks whether a 1 has been seen in the current word. Until that happens the input bit is passed through. Once it has happened, every later input bit is inverted.

A word starts on the first cycle in which the enable input is sampled high after it was low, and the serial input bit in that cycle is bit 0. Exactly `WIDTH` bits are taken while enable stays high. The block then parks in a finished state and ignores the serial input until enable drops and rises again. Dropping enable in the middle of a word abandons that word. Each output bit is registered and appears one clock after its input bit was sampled. In every cycle that carries no result bit, the output is 0.

Top module: `twc_serial_negator`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, the serial output is 0.
- R2: Bit k of the result is on the output during the clock period after the edge that sampled input bit k, with bit 0 (least significant) first.
- R3: Input bits up to and including the first 1 bit of a word, counted from bit 0, appear on the output unchanged.
- R4: Every input bit after the first 1 bit of a word appears on the output inverted.
- R5: A word starts at the first edge where enable is high after having been low at the previous edge, and the "one seen" flag is clear at that start. Holding enable high does not start another word.
- R6: After `WIDTH` bits of a word have been taken, the output is 0 and input bits are ignored for as long as enable stays high.
- R7: Whenever enable is sampled low, the output in the next period is 0 and any partial word is abandoned. The next rising enable starts a fresh word.
- R8: `WIDTH` defaults to 8. An all-zero word negates to all zeros, and the word with only the top bit set negates to itself.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Enable; a rising level starts a word, a low level aborts it |
| x_i | input | 1 | Serial input bit, least significant first |
| y_o | output | 1 | Registered serial output bit of the negated word |

## Verification
A flag that is set too early or cleared too late shows up at the output as an inverted bit, one period after the offending input bit. A stale flag carried over from the previous word corrupts bit 0 or 1 of the next word. A bit counter that is off by one either truncates the word, so the top result bit reads 0, or lets one extra input bit through after the word has ended. Either fault is visible on the first affected bit. The scoreboard predicts every output bit from the arithmetic negation modulo 2^WIDTH, so any such fault is reported in the same period it appears.

// File: rtl/twc_pkg.sv
package twc_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_DONE = 2'd2
   } twc_state_e;

   function automatic int twc_cnt_bits(input int width);
      return $clog2(width + 1);
   endfunction

endpackage

// File: rtl/twc_rise_detect.sv
module twc_rise_detect (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic lvl_i,
   output logic rise_o
);

   logic lvl_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) lvl_q <= 1'b0;
      else         lvl_q <= lvl_i;
   end

   assign rise_o = lvl_i & ~lvl_q;

endmodule

// File: rtl/twc_bit_counter.sv
module twc_bit_counter #(
   parameter int WIDTH = 8
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic take_i,
   output logic last_o
);

   localparam int CW = twc_pkg::twc_cnt_bits(WIDTH);
   localparam logic [CW-1:0] LAST_IDX = CW'(WIDTH - 1);
   localparam logic [CW-1:0] FULL     = CW'(WIDTH);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     cnt_q <= '0;
      else if (take_i) cnt_q <= cnt_q + 1'b1;
      else             cnt_q <= '0;
   end

   assign last_o = take_i && (cnt_q == LAST_IDX);

   AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_q <= FULL)) else $error("count past width"); // R6

   AST_NO_TAKE_WHEN_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_q == FULL) |-> !take_i) else $error("bit taken beyond width"); // R6

endmodule

// File: rtl/twc_negate_cell.sv
module twc_negate_cell (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic take_i,
   input  logic x_i,
   output logic seen_o,
   output logic y_o
);

   logic seen_q;
   logic y_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         seen_q <= 1'b0;
         y_q    <= 1'b0;
      end else if (take_i) begin
         y_q    <= seen_q ? ~x_i : x_i;
         seen_q <= seen_q | x_i;
      end else begin
         y_q    <= 1'b0;
         seen_q <= 1'b0;
      end
   end

   assign seen_o = seen_q;
   assign y_o    = y_q;

   AST_COPY_BEFORE_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (take_i && !seen_q) |=> (y_q == $past(x_i))) else $error("copy phase wrong"); // R3

   AST_INVERT_AFTER_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (take_i && seen_q) |=> (y_q == !$past(x_i))) else $error("invert phase wrong"); // R4

endmodule

// File: rtl/twc_serial_negator.sv
module twc_serial_negator #(
   parameter int WIDTH = 8
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic en_i,
   input  logic x_i,
   output logic y_o
);
   import twc_pkg::*;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("twc_serial_negator: WIDTH must be at least 2");
      end
   endgenerate

   twc_state_e state_q, state_d;
   logic start, take, last, seen;

   twc_rise_detect u_rise (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .lvl_i  (en_i),
      .rise_o (start)
   );

   assign take = start | ((state_q == ST_RUN) & en_i);

   twc_bit_counter #(.WIDTH(WIDTH)) u_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .take_i (take),
      .last_o (last)
   );

   twc_negate_cell u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .take_i (take),
      .x_i    (x_i),
      .seen_o (seen),
      .y_o    (y_o)
   );

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: if (start) state_d = ST_RUN;
         ST_RUN: begin
            if (!en_i)     state_d = ST_IDLE;
            else if (last) state_d = ST_DONE;
         end
         ST_DONE: if (!en_i) state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) state_q <= ST_IDLE;
      else         state_q <= state_d;
   end

   AST_OUT_LOW_AFTER_RESET: assert property (@(posedge clk_i)
      !rst_ni |=> !y_o) else $error("output high after reset"); // R1

   AST_START_CLEAN_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start |-> !seen) else $error("flag set at word start"); // R5

   AST_START_TO_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start |=> (state_q == ST_RUN)) else $error("start did not enter run"); // R5

   AST_DONE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == ST_DONE) |=> !y_o) else $error("output active when done"); // R6

   AST_EN_LOW_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i |=> (!y_o && state_q == ST_IDLE)) else $error("enable low not idle"); // R7

endmodule

// File: tb/twc_serial_negator_tb.sv
module twc_serial_negator_tb_top;
   localparam int N = 8;

   typedef struct {
      logic  exp;
      string tag;
   } item_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic en = 1'b0;
   logic x = 1'b0;
   logic y;

   int checks = 0;
   int fails = 0;
   bit finished = 0;
   item_t sb_q[$];

   always #2 clk = ~clk;

   twc_serial_negator #(.WIDTH(N)) dut_i (
      .clk_i  (clk),
      .rst_ni (rst_n),
      .en_i   (en),
      .x_i    (x),
      .y_o    (y)
   );

   function automatic void check(input logic act, input logic exp, input string tag);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: y=%0b expected %0b at %0t", tag, act, exp, $time);
      end
   endfunction

   // monitor: pops every expectation pushed at the preceding rising edge
   always @(negedge clk) begin
      while (sb_q.size() > 0) begin
         item_t it;
         it = sb_q.pop_front();
         check(y, it.exp, it.tag);
      end
   end

   // driver: present one bit, after the sampling edge queue its expected result
   task automatic drive_bit(input logic xv, input logic env, input logic expb, input string tag);
      item_t it;
      @(negedge clk);
      x  = xv;
      en = env;
      @(posedge clk);
      it.exp = expb;
      it.tag = tag;
      sb_q.push_back(it);
   endtask

   // full word; en must be low on entry; leaves en low
   task automatic send_word(input logic [N-1:0] v, input string force_tag, input int extra);
      logic [N-1:0] neg;
      bit seen1;
      string tag;
      neg = (~v) + 1'b1;
      seen1 = 0;
      for (int i = 0; i < N; i++) begin
         if (force_tag != "") tag = force_tag;
         else if (i == 0)     tag = "R2";
         else                 tag = seen1 ? "R4" : "R3";
         drive_bit(v[i], 1'b1, neg[i], tag);
         if (v[i]) seen1 = 1;
      end
      for (int k = 0; k < extra; k++) drive_bit(k[0] ^ 1'b1, 1'b1, 1'b0, "R6");
      drive_bit(1'b1, 1'b0, 1'b0, "R7");
   endtask

   initial begin
      for (int c = 0; c < 20000; c++) begin
         @(posedge clk);
         if (finished) break;
      end
      if (!finished) begin
         fails++;
         checks++;
         $display("FAIL watchdog: run did not complete");
         $display("[TB] %0d tests run, %0d failed", checks, fails);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      check(y, 1'b0, "R1");
      rst_n = 1'b1;
      @(negedge clk);
      check(y, 1'b0, "R1");

      // R8 corners and fixed patterns
      send_word(8'h00, "R8", 1);
      send_word(8'h80, "R8", 1);
      send_word(8'h01, "", 2);
      send_word(8'hFF, "", 0);
      send_word(8'h7F, "", 0);
      send_word(8'hA4, "", 0);

      // R6: enable held high long after the word with busy input
      send_word(8'h18, "", 6);

      // R7: abort mid-word, then a fresh word must start clean (R5)
      drive_bit(1'b0, 1'b1, 1'b0, "R3");
      drive_bit(1'b1, 1'b1, 1'b1, "R3");
      drive_bit(1'b1, 1'b1, 1'b0, "R4");
      drive_bit(1'b1, 1'b0, 1'b0, "R7");
      drive_bit(1'b1, 1'b0, 1'b0, "R7");
      send_word(8'h02, "R5", 0);

      // random words
      for (int r = 0; r < 25; r++) begin
         logic [N-1:0] v;
         v = N'($urandom);
         send_word(v, "", r % 3);
      end

      repeat (2) @(negedge clk);
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
   end

endmodule